// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer

This block holds three independent interval timers that all run from one master tick (nominally 1.024 MHz, given as a one-cycle enable on the system clock). Each timer divides the master tick with a fixed prescaler. It then counts prescaled steps up to an 8-bit programmable period. Each time the period completes, it bumps a 4-bit event counter that software polls.

A small register bus reaches the timers. It has an address, write data with a write strobe, and a read strobe with combinational read data. The three period registers come first, followed by the three event counters, so software can compute a timer's counter address from its period address. Reading a counter hands back the events that piled up since the last look and clears the count in the same access. An external control register drives one enable bit per timer, and a rising enable restarts that timer from a clean state.

Top module: `ivt_timers`

## Requirements
- R1: After reset every event counter reads 0 and every period behaves as 256.
- R2: Timers 0 and 1 take one internal step per PRE_SLOW master ticks. Timer 2 takes one step per PRE_FAST master ticks. The defaults are 128 and 16.
- R3: With period value P in 1..255, a timer's event counter rises by one every P internal steps. A written value of 0 gives a period of 256.
- R4: The event counter is 4 bits wide and wraps from 15 to 0.
- R5: With rd_en high at a counter address, rdata shows the counter in bits 3:0 (upper bits 0) in that cycle, and the counter is 0 after the clock edge.
- R6: A write of any data to a counter address clears that counter.
- R7: On the first clock edge where a timer's enable is seen high after being low, its prescaler, step count and event counter all return to 0. The first increment then lands exactly PRE·P master ticks later.
- R8: While a timer's enable is low it does not advance, and its counter holds its value and can still be read.
- R9: If a clearing access and an increment fall on the same edge, the counter becomes 1.
- R10: The period registers are write-only and read as 0. Addresses 6 and 7 also read as 0, and any read with rd_en low returns 0.
- R11: Only clock edges with tick high advance the prescalers.
- R12: The period registers of timers 0, 1 and 2 are at addresses 0, 1 and 2. Their event counters are at addresses 3, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Master tick enable, one cycle per master clock |
| enable | input | 3 | Per-timer enable from the external control register |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, valid while rd_en is high |

## Verification
The bench builds the block with PRE_SLOW = 4 and PRE_FAST = 2, keeping the slow/fast split between the first two timers and the third. With these values the cycles to one increment drop to a few master ticks. The bench can then sweep every timer across periods 1 to 6 and several elapsed-time points, including the cycle just before and the cycle of an increment, and several full 16-count wraps. The same short prescalers also make the 255 and 0 (256) periods and the reset-default period reachable within the run length.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
package ivt_pkg;

    localparam int PERIOD_W = 8;
    localparam int CNT_W    = 4;
    localparam int DATA_W   = 8;

    typedef logic [PERIOD_W-1:0] period_t;
    typedef logic [CNT_W-1:0]    cnt_t;

    typedef struct packed {
        logic period_we;
        logic cnt_clr;
    } chan_ctl_t;

    function automatic int unsigned pick_prescale(int unsigned idx,
                                                  int unsigned slow_count,
                                                  int unsigned pre_slow,
                                                  int unsigned pre_fast);
        return (idx < slow_count) ? pre_slow : pre_fast;
    endfunction

endpackage

// File: rtl/ivt_decode.sv
`timescale 1ns/1ps
module ivt_decode #(
    parameter int NUM    = 3,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output ivt_pkg::chan_ctl_t ctl [NUM],
    output logic [NUM-1:0]    cnt_rd_sel
);
    // periods occupy 0..NUM-1, counters NUM..2*NUM-1
    localparam int CNT_BASE = NUM;

    logic [NUM-1:0] pwe_vec;
    logic [NUM-1:0] clr_vec;

    for (genvar i = 0; i < NUM; i++) begin : g_dec
        logic hit_period;
        logic hit_count;
        assign hit_period      = (addr == ADDR_W'(i));
        assign hit_count       = (addr == ADDR_W'(CNT_BASE + i));
        assign pwe_vec[i]      = wr_en & hit_period;
        assign clr_vec[i]      = (wr_en | rd_en) & hit_count;
        assign cnt_rd_sel[i]   = rd_en & hit_count;
        assign ctl[i].period_we = pwe_vec[i];
        assign ctl[i].cnt_clr   = clr_vec[i];
    end

    // one register at most is targeted by any access
    assert_one_target_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pwe_vec, clr_vec}));

endmodule

// File: rtl/ivt_channel.sv
`timescale 1ns/1ps
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int PRESCALE = 128
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      enable,
    input  chan_ctl_t ctl,
    input  period_t   wdata,
    output cnt_t      count
);
    localparam int PRE_W      = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int FULL_W     = PERIOD_W + 1;
    localparam logic [FULL_W-1:0] PERIOD_MAX = FULL_W'(1) << PERIOD_W;

    logic [PRE_W-1:0]  pre_q;
    period_t           stage_q;
    logic [FULL_W-1:0] period_q;
    logic              en_q;
    cnt_t              cnt_q;

    logic              en_rise;
    logic              pre_wrap;
    logic              stage_tick;
    logic [FULL_W-1:0] stage_nxt;
    logic              stage_done;
    logic              inc;

    always_comb begin
        en_rise    = enable & ~en_q;
        pre_wrap   = (pre_q == PRE_W'(PRESCALE - 1));
        stage_tick = enable & tick & pre_wrap;
        stage_nxt  = {1'b0, stage_q} + FULL_W'(1);
        stage_done = stage_tick & (stage_nxt >= period_q);
        inc        = stage_done & ~en_rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q    <= '0;
            stage_q  <= '0;
            period_q <= PERIOD_MAX;
            en_q     <= 1'b0;
            cnt_q    <= '0;
        end else begin
            en_q <= enable;
            if (ctl.period_we && (wdata != period_q[PERIOD_W-1:0]))
                period_q <= (wdata == '0) ? PERIOD_MAX : {1'b0, wdata};
            if (en_rise) begin
                pre_q   <= '0;
                stage_q <= '0;
                cnt_q   <= '0;
            end else begin
                if (enable && tick)
                    pre_q <= pre_wrap ? '0 : pre_q + PRE_W'(1);
                if (stage_tick)
                    stage_q <= stage_done ? '0 : stage_nxt[PERIOD_W-1:0];
                if (ctl.cnt_clr)
                    cnt_q <= inc ? cnt_t'(1) : '0;
                else if (inc)
                    cnt_q <= cnt_q + cnt_t'(1);
            end
        end
    end

    assign count = cnt_q;

    assert_hold_when_off_R8: assert property (@(posedge clk) disable iff (rst)
        (!enable && !ctl.cnt_clr) |=> $stable(cnt_q));

    assert_clear_result_R9: assert property (@(posedge clk) disable iff (rst)
        ctl.cnt_clr |=> (cnt_q <= cnt_t'(1)));

    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (enable && !en_q) |=> (cnt_q == '0 && stage_q == '0 && pre_q == '0));

    assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctl.cnt_clr && !(enable && !en_q)) |=>
            (cnt_q == $past(cnt_q) || cnt_q == cnt_t'($past(cnt_q) + 1'b1)));

    assert_period_range_R3: assert property (@(posedge clk) disable iff (rst)
        (period_q != '0) && (period_q <= PERIOD_MAX));

endmodule

// File: rtl/ivt_timers.sv
`timescale 1ns/1ps
module ivt_timers
    import ivt_pkg::*;
#(
    parameter int NUM_TIMERS = 3,
    parameter int SLOW_COUNT = 2,
    parameter int PRE_SLOW   = 128,
    parameter int PRE_FAST   = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic [NUM_TIMERS-1:0] enable,
    input  logic [2:0]            addr,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  rd_en,
    output logic [DATA_W-1:0]     rdata
);
    localparam int ADDR_W = 3;

    chan_ctl_t      ctl [NUM_TIMERS];
    logic [NUM_TIMERS-1:0] cnt_rd_sel;
    cnt_t           counts [NUM_TIMERS];

    ivt_decode #(
        .NUM    (NUM_TIMERS),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .clk        (clk),
        .rst        (rst),
        .addr       (addr),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .ctl        (ctl),
        .cnt_rd_sel (cnt_rd_sel)
    );

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chan
        localparam int PRE_I = int'(pick_prescale(i, SLOW_COUNT, PRE_SLOW, PRE_FAST));
        ivt_channel #(
            .PRESCALE (PRE_I)
        ) u_chan (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .enable (enable[i]),
            .ctl    (ctl[i]),
            .wdata  (wdata[PERIOD_W-1:0]),
            .count  (counts[i])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_TIMERS; i++)
            if (cnt_rd_sel[i])
                rdata = DATA_W'(counts[i]);
    end

    assert_period_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (int'(addr) < NUM_TIMERS) |-> (rdata == '0));

endmodule

// File: tb/tb_ivt_timers.sv
`timescale 1ns/1ps
module tb_ivt_timers;
    localparam int PS = 4;
    localparam int PF = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic [2:0] enable = '0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    ivt_timers #(.NUM_TIMERS(3), .SLOW_COUNT(2), .PRE_SLOW(PS), .PRE_FAST(PF)) dut (
        .clk(clk), .rst(rst), .tick(tick), .enable(enable), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rdata(rdata));

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        summary();
        $finish;
    end

    task automatic check(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_edges(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic bus_wr(int a, int d);
        addr = 3'(a); wdata = 8'(d); wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(int a, output int v);
        addr = 3'(a); rd_en = 1'b1;
        #1 v = int'(rdata);
        step();
        rd_en = 1'b0;
    endtask

    function automatic int span(int ch, int p);
        return ((ch < 2) ? PS : PF) * ((p == 0) ? 256 : p);
    endfunction

    // disable, program period, enable: returns just after the restart edge
    task automatic arm(int ch, int p);
        enable[ch] = 1'b0;
        step();
        bus_wr(ch, p);
        enable[ch] = 1'b1;
        step();
    endtask

    task automatic sweep_point(int ch, int p, int n);
        int v;
        int t;
        t = span(ch, p);
        arm(ch, p);
        wait_edges(n);
        bus_rd(3 + ch, v);
        check($sformatf("R2 R3 R4 R12 ch%0d p%0d n%0d", ch, p, n), v, (n / t) % 16);
        bus_rd(3 + ch, v);
        check($sformatf("R5 R9 ch%0d p%0d n%0d", ch, p, n), v, (((n + 1) % t) == 0) ? 1 : 0);
    endtask

    initial begin
        int v;
        int t;
        int mult [4] = '{0, 1, 3, 17};
        wait_edges(3);
        rst = 1'b0;
        step();

        // R1: counters clear out of reset
        for (int ch = 0; ch < 3; ch++) begin
            bus_rd(3 + ch, v);
            check("R1 counter after reset", v, 0);
        end
        // R1: default period acts as 256 on timer 2
        enable[2] = 1'b1;
        step();
        wait_edges(PF * 256 - 1);
        bus_rd(5, v);
        check("R1 default period before first event", v, 0);
        bus_rd(5, v);
        check("R1 R9 default period event on clearing edge", v, 1);

        // R2 R3 R4 R5 R9 R12: sweep timers, periods and elapsed times
        for (int ch = 0; ch < 3; ch++)
            for (int p = 1; p <= 6; p++)
                for (int mi = 0; mi < 4; mi++)
                    for (int off = 0; off < 2; off++) begin
                        int n;
                        n = mult[mi] * span(ch, p) - off;
                        if (n >= 0) sweep_point(ch, p, n);
                    end
        // R3: extreme periods
        sweep_point(2, 0, 17 * span(2, 0));
        sweep_point(2, 255, 17 * span(2, 255) - 1);
        sweep_point(0, 255, 2 * span(0, 255));
        sweep_point(1, 0, span(1, 0) - 1);

        // R6: write to counter address clears it
        t = span(1, 3);
        arm(1, 3);
        wait_edges(3 * t);
        bus_wr(4, 8'hA5);
        bus_rd(4, v);
        check("R6 write clears counter", v, 0);

        // R8: disabled timer holds its count
        t = span(0, 2);
        arm(0, 2);
        wait_edges(2 * t);
        enable[0] = 1'b0;
        wait_edges(5 * t);
        bus_rd(3, v);
        check("R8 count held while disabled", v, 2);

        // R7: re-enable restarts the counter from zero
        enable[0] = 1'b1;
        step();
        wait_edges(t - 1);
        bus_rd(3, v);
        check("R7 restart clears count", v, 0);
        bus_rd(3, v);
        check("R7 first event after full interval", v, 1);

        // R11: edges without tick do not count
        t = span(2, 2);
        arm(2, 2);
        tick = 1'b0;
        wait_edges(3 * t);
        bus_rd(5, v);
        check("R11 no progress without tick", v, 0);
        tick = 1'b1;
        wait_edges(t);
        bus_rd(5, v);
        check("R11 progress resumes with tick", v, 1);

        // R10: period addresses and unused addresses read zero
        bus_wr(0, 7);
        bus_wr(1, 9);
        bus_wr(2, 11);
        for (int a = 0; a < 3; a++) begin
            bus_rd(a, v);
            check($sformatf("R10 period addr %0d", a), v, 0);
        end
        for (int a = 6; a < 8; a++) begin
            bus_rd(a, v);
            check($sformatf("R10 unused addr %0d", a), v, 0);
        end
        addr = 3'd3;
        #1 check("R10 no read strobe", int'(rdata), 0);

        // R12: independent channels at their own addresses
        enable = '0;
        step();
        bus_wr(0, 3);
        bus_wr(1, 5);
        bus_wr(2, 7);
        enable = 3'b111;
        step();
        wait_edges(60);
        bus_rd(3, v);
        check("R12 timer0 at addr 3", v, (60 / span(0, 3)) % 16);
        bus_rd(4, v);
        check("R12 timer1 at addr 4", v, (61 / span(1, 5)) % 16);
        bus_rd(5, v);
        check("R12 timer2 at addr 5", v, (62 / span(2, 7)) % 16);

        summary();
        $finish;
    end

endmodule